// File: doc/BRIEF.md
# I2C Bus Error Detector

This block watches an I2C bus and the module's own SDA and SCL drive to catch three faults: a bus held with SCL low for too long, a collision where another device pulls SDA low while the module has released both lines, and a NACK seen on the acknowledge clock while the module is taking part in a transfer. Each fault sets its own sticky flag. The flags sit in one software register next to an enable bit per flag. A read-only summary bit reports whether any flag is set. An interrupt request is raised for the flags that are enabled.

Recovery after a time-out depends on the role that is active. As a target, the block pulses a request that clears the target-active and clock-stretch status and pulses a module reset. As a controller, it pulses a request for a stop condition. The time-out limit is a programmable count of ticks. The tick itself comes from clock selection logic outside the block.

Top module: `i2c_err_mon`

## Requirements
- R1: While the synchronized SCL is low and `tgt_active` or `ctl_active` is high, the time-out counter advances on each cycle with `tmo_tick` high. The time-out flag (bit 0) sets on the clock edge that samples the `tmo_limit`-th such tick. The count restarts from zero whenever the synchronized SCL is high or both role inputs are low.
- R2: A `tmo_limit` of zero disables the time-out, so no number of ticks sets the flag.
- R3: A time-out with `tgt_active` high makes `tgt_clr` and `mod_rst` high for exactly one cycle, in the same cycle the time-out flag first reads set.
- R4: A time-out with `ctl_active` high makes `stop_req` high for exactly one cycle, in the same cycle the time-out flag first reads set. `mod_rst` and `tgt_clr` stay low unless `tgt_active` is also high.
- R5: The collision flag (bit 1) sets when the synchronized SDA is low while `sda_rel` and `scl_rel` are both high. It is visible on the third clock edge after `sda_in` falls. It does not set while either release input is low.
- R6: The NACK flag (bit 2) sets on a rising edge of the synchronized SCL when `ack_slot` is high, a role input is high and the synchronized SDA is high. It is visible on the third clock edge after `scl_in` rises. A low SDA, a low `ack_slot` or no active role gives no flag.
- R7: The register layout is `reg_rdata[2:0]` = flags {NACK, collision, time-out} and `reg_rdata[5:3]` = enables in the same order. A write with `reg_we` loads both fields from `reg_wdata`, so software can clear or set any flag. A hardware set in the cycle of the write wins for that flag.
- R8: `err_sum` is high whenever any flag is set and low only when all three flags are clear. It is updated in the same cycle as the flags.
- R9: `err_irq` is high when any flag is set together with its enable bit. Flags set whether or not they are enabled.
- R10: After a synchronous reset, all flags, enables, `err_sum`, `err_irq` and the three recovery pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| scl_rel | input | 1 | Module's own SCL output is released (high) |
| sda_rel | input | 1 | Module's own SDA output is released (high) |
| tgt_active | input | 1 | Module is an active target |
| ctl_active | input | 1 | Module is an active controller |
| ack_slot | input | 1 | The current SCL pulse is the 9th (acknowledge) pulse |
| tmo_tick | input | 1 | Time-out time-base enable |
| tmo_limit | input | TMO_W | Time-out limit in ticks; zero disables |
| reg_we | input | 1 | Write strobe for the flag/enable register |
| reg_wdata | input | 6 | Write data: enables [5:3], flags [2:0] |
| reg_rdata | output | 6 | Read data: enables [5:3], flags [2:0] |
| err_sum | output | 1 | Read-only summary of all error flags |
| err_irq | output | 1 | Interrupt request from enabled flags |
| tgt_clr | output | 1 | One-cycle pulse clearing target-active and clock-stretch status |
| mod_rst | output | 1 | One-cycle module reset pulse |
| stop_req | output | 1 | One-cycle stop-condition request |

## Verification
A software write to the flag register and a hardware flag set can land on the same clock edge. The bench provokes this with a write of all zeros in the exact cycle that carries the expiring time-out tick, after a collision flag has been set earlier by software. The expected result is that the time-out flag survives, the software-set flag is cleared, and the target recovery pulses still fire in the following cycle. The bench also makes a fault flag set while its enable is clear, to show that the summary bit and the interrupt request diverge.

// File: rtl/i2c_err_pkg.sv
package i2c_err_pkg;

    localparam int ERR_N = 3;
    localparam int REG_W = 2 * ERR_N;

    // bit 2 = NACK, bit 1 = collision, bit 0 = time-out
    typedef struct packed {
        logic nack;
        logic bcl;
        logic tmo;
    } err_vec_t;

    typedef struct packed {
        logic stop_req;
        logic mod_rst;
        logic tgt_clr;
    } recov_t;

    function automatic logic any_err(input err_vec_t e);
        return |e;
    endfunction

    function automatic logic any_enabled(input err_vec_t e, input err_vec_t en);
        return |(e & en);
    endfunction

endpackage

// File: rtl/i2c_err_sync.sv
module i2c_err_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/i2c_err_tmo.sv
module i2c_err_tmo #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             scl_low,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             at_last;

    assign armed   = active && scl_low && (limit != '0);
    assign at_last = (cnt >= limit - CNT_W'(1));
    assign expire  = armed && tick && at_last;

    always_ff @(posedge clk) begin
        if (rst || !armed) cnt <= '0;
        else if (expire)   cnt <= '0;
        else if (tick)     cnt <= cnt + CNT_W'(1);
    end

    // R1: an idle module holds no partial count
    p_idle_clear_r1: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0));
endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags
    import i2c_err_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  err_vec_t hw_set,
    input  logic     we,
    input  err_vec_t wflag,
    input  err_vec_t wen,
    output err_vec_t flags,
    output err_vec_t en,
    output logic     sum,
    output logic     irq
);
    logic [ERR_N-1:0] hw_v, wf_v, fl_v, fl_n;
    err_vec_t         flags_n, en_n;

    assign hw_v = hw_set;
    assign wf_v = wflag;
    assign fl_v = flags;

    for (genvar i = 0; i < ERR_N; i++) begin : g_bit
        assign fl_n[i] = hw_v[i] | (we ? wf_v[i] : fl_v[i]);
    end

    assign flags_n = fl_n;
    assign en_n    = we ? wen : en;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            en    <= '0;
            sum   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            flags <= flags_n;
            en    <= en_n;
            sum   <= any_err(flags_n);
            irq   <= any_enabled(flags_n, en_n);
        end
    end

    // R7: a hardware set is never lost to a write
    p_hw_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));
    // R8: summary follows any flag
    p_sum_cover_r8: assert property (@(posedge clk) disable iff (rst)
        (flags != '0) |-> sum);
    p_sum_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !sum);
    // R9: request only with a flag present
    p_irq_sub_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> sum);
endmodule

// File: rtl/i2c_err_mon.sv
module i2c_err_mon
    import i2c_err_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             scl_rel,
    input  logic             sda_rel,
    input  logic             tgt_active,
    input  logic             ctl_active,
    input  logic             ack_slot,
    input  logic             tmo_tick,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             reg_we,
    input  logic [5:0]       reg_wdata,
    output logic [5:0]       reg_rdata,
    output logic             err_sum,
    output logic             err_irq,
    output logic             tgt_clr,
    output logic             mod_rst,
    output logic             stop_req
);
    logic     scl_s, sda_s, scl_d, scl_rise;
    logic     role_on, expire;
    err_vec_t hw, flags, en;
    recov_t   recov_q;

    i2c_err_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
    i2c_err_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

    always_ff @(posedge clk) begin
        if (rst) scl_d <= 1'b1;
        else     scl_d <= scl_s;
    end

    assign scl_rise = scl_s & ~scl_d;
    assign role_on  = tgt_active | ctl_active;

    i2c_err_tmo #(.CNT_W(TMO_W)) u_tmo (
        .clk(clk), .rst(rst), .tick(tmo_tick), .scl_low(~scl_s),
        .active(role_on), .limit(tmo_limit), .expire(expire));

    assign hw.tmo  = expire;
    assign hw.bcl  = ~sda_s & sda_rel & scl_rel;
    assign hw.nack = scl_rise & ack_slot & role_on & sda_s;

    i2c_err_flags u_flags (
        .clk(clk), .rst(rst), .hw_set(hw), .we(reg_we),
        .wflag(err_vec_t'(reg_wdata[ERR_N-1:0])),
        .wen(err_vec_t'(reg_wdata[REG_W-1:ERR_N])),
        .flags(flags), .en(en), .sum(err_sum), .irq(err_irq));

    always_ff @(posedge clk) begin
        if (rst) begin
            recov_q <= '0;
        end else begin
            recov_q.tgt_clr  <= expire & tgt_active;
            recov_q.mod_rst  <= expire & tgt_active;
            recov_q.stop_req <= expire & ctl_active;
        end
    end

    assign tgt_clr   = recov_q.tgt_clr;
    assign mod_rst   = recov_q.mod_rst;
    assign stop_req  = recov_q.stop_req;
    assign reg_rdata = {en, flags};

    // R3: reset request is a single-cycle pulse tied to a time-out flag
    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mod_rst |=> !mod_rst);
    p_rst_flag_r3: assert property (@(posedge clk) disable iff (rst)
        mod_rst |-> (flags.tmo && err_sum));
    // R4: stop request is a single-cycle pulse tied to a time-out flag
    p_stop_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req);
    p_stop_flag_r4: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> flags.tmo);
    // R6: no NACK flag rises without a role active one edge earlier
    p_nack_role_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags.nack) && !$past(reg_we)) |-> $past(role_on));
endmodule

// File: tb/i2c_err_mon_tb.sv
module i2c_err_mon_tb_top;
    localparam int CLK_P = 10;
    localparam int TMO_W = 16;
    localparam int NVEC  = 11;

    // {sda, scl_final, sda_rel, scl_rel, ack_slot, tgt, ctl, exp{nack,bcl,tmo}}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b1_1_1_1_0_0_0_000,  // idle bus
        10'b0_1_1_1_0_0_0_010,  // collision
        10'b0_1_0_1_0_0_0_000,  // own SDA low
        10'b0_1_1_0_0_0_0_000,  // own SCL low
        10'b1_1_1_1_1_1_0_100,  // NACK as target
        10'b1_1_1_1_1_0_1_100,  // NACK as controller
        10'b1_1_1_1_1_0_0_000,  // no role
        10'b0_1_0_1_1_1_0_000,  // ACK
        10'b1_1_1_1_0_1_0_000,  // not ack slot
        10'b0_1_1_1_1_0_1_010,  // collision, not NACK
        10'b1_0_1_1_1_1_0_000   // no SCL rise
    };

    logic clk = 1'b0;
    logic rst, scl_in, sda_in, scl_rel, sda_rel, tgt_active, ctl_active;
    logic ack_slot, tmo_tick, reg_we;
    logic [TMO_W-1:0] tmo_limit;
    logic [5:0] reg_wdata, reg_rdata;
    logic err_sum, err_irq, tgt_clr, mod_rst, stop_req;
    int total = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_err_mon #(.TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rel(scl_rel), .sda_rel(sda_rel), .tgt_active(tgt_active),
        .ctl_active(ctl_active), .ack_slot(ack_slot), .tmo_tick(tmo_tick),
        .tmo_limit(tmo_limit), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_sum(err_sum), .err_irq(err_irq),
        .tgt_clr(tgt_clr), .mod_rst(mod_rst), .stop_req(stop_req));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [5:0] d);
        reg_we = 1'b1; reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tmo_tick = 1'b1;
            step(1);
        end
        tmo_tick = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; scl_in = 1'b1; sda_in = 1'b1; scl_rel = 1'b1; sda_rel = 1'b1;
        tgt_active = 1'b0; ctl_active = 1'b0; ack_slot = 1'b0; tmo_tick = 1'b0;
        tmo_limit = '0; reg_we = 1'b0; reg_wdata = '0;
        step(3);
        rst = 1'b0;
        step(1);
        // R10 reset state
        chk("R10 rdata", reg_rdata, 0);
        chk("R10 sum/irq", {err_sum, err_irq}, 0);
        chk("R10 pulses", {tgt_clr, mod_rst, stop_req}, 0);

        // vector walk: R5 collision and R6 NACK patterns
        for (int i = 0; i < NVEC; i++) begin
            sda_in = VEC[i][9]; sda_rel = VEC[i][7]; scl_rel = VEC[i][6];
            ack_slot = VEC[i][5]; tgt_active = VEC[i][4]; ctl_active = VEC[i][3];
            scl_in = 1'b0;
            step(4);
            wr(6'b000_000);
            scl_in = VEC[i][8];
            step(4);
            chk($sformatf("R5/R6 row %0d flags", i), reg_rdata[2:0], VEC[i][2:0]);
        end
        ack_slot = 1'b0; sda_in = 1'b1; sda_rel = 1'b1; scl_rel = 1'b1;
        tgt_active = 1'b0; ctl_active = 1'b0; scl_in = 1'b1;
        step(4);
        wr(6'b000_000);

        // R1/R3 target time-out
        tmo_limit = 5; tgt_active = 1'b1; scl_in = 1'b0;
        step(3);
        ticks(4);
        chk("R1 no flag before limit", reg_rdata[0], 0);
        chk("R3 no pulse before limit", mod_rst, 0);
        ticks(1);
        chk("R1 flag at limit", reg_rdata[0], 1);
        chk("R3 target pulses", {tgt_clr, mod_rst, stop_req}, 3'b110);
        step(1);
        chk("R3 single cycle", {tgt_clr, mod_rst}, 0);
        tgt_active = 1'b0; scl_in = 1'b1;
        step(3);
        wr(6'b000_000);

        // R4 controller time-out
        ctl_active = 1'b1; scl_in = 1'b0;
        step(3);
        ticks(5);
        chk("R4 controller pulses", {tgt_clr, mod_rst, stop_req}, 3'b001);
        step(1);
        chk("R4 single cycle", stop_req, 0);
        scl_in = 1'b1;
        step(3);
        wr(6'b000_000);

        // R1 SCL high restarts the count
        scl_in = 1'b0;
        step(3);
        ticks(3);
        scl_in = 1'b1;
        step(3);
        scl_in = 1'b0;
        step(3);
        ticks(4);
        chk("R1 restart after SCL high", reg_rdata[0], 0);
        ticks(1);
        chk("R1 expire after restart", reg_rdata[0], 1);
        ctl_active = 1'b0; scl_in = 1'b1;
        step(3);
        wr(6'b000_000);

        // R1 idle: no counting
        scl_in = 1'b0;
        step(3);
        ticks(10);
        chk("R1 idle no time-out", reg_rdata[0], 0);

        // R2 zero limit disables
        tmo_limit = 0; tgt_active = 1'b1;
        ticks(20);
        chk("R2 zero limit", {reg_rdata[0], mod_rst}, 0);
        tgt_active = 1'b0; scl_in = 1'b1; tmo_limit = 5;
        step(3);

        // R9 interrupt enables
        wr(6'b010_000);
        sda_in = 1'b0;
        step(4);
        chk("R9 enabled flag irq", {err_irq, err_sum}, 2'b11);
        chk("R7 layout", reg_rdata, 6'b010_010);
        sda_in = 1'b1;
        step(3);
        wr(6'b100_010);
        chk("R9 disabled flag no irq", {err_irq, err_sum}, 2'b01);

        // R8 summary clears only when all clear
        wr(6'b000_110);
        chk("R7 software set", reg_rdata, 6'b000_110);
        wr(6'b000_100);
        chk("R8 one flag left", err_sum, 1);
        wr(6'b000_000);
        chk("R8 all clear", err_sum, 0);

        // R7 write and hardware set in the same cycle
        tgt_active = 1'b1; scl_in = 1'b0;
        step(3);
        wr(6'b000_010);
        ticks(4);
        tmo_tick = 1'b1; reg_we = 1'b1; reg_wdata = 6'b000_000;
        step(1);
        tmo_tick = 1'b0; reg_we = 1'b0;
        chk("R7 hw set wins, sw clear applied", reg_rdata[2:0], 3'b001);
        chk("R3 pulse with concurrent write", mod_rst, 1);
        chk("R8 sum with concurrent write", err_sum, 1);

        finish_run();
    end
endmodule